// File: doc/BRIEF.md
# Segment Playback Controller for a Shared Profile Memory

This block owns a 1024-word by 32-bit profile memory that has one port. Two parties use that port. A host writes words into it through a simple write strobe, which is the parallel side of a serial configuration link. A playback sequencer reads the words back and streams them out.

Playback is organised in four segments. Each segment has its own control word, which sets:

- a start address and an end address,
- a step interval,
- a mode,
- a flag that selects what the output shows once the segment is finished.

A start pulse picks one segment. The sequencer reads that segment's words in ascending address order and presents each one on a registered output together with a one-cycle strobe. Host writes always win the port. A write that arrives when a read is due pushes that read back, and no word is lost.

A typical user loads a table of tuning or phase words into the memory and programs the segment words. It then fires segments as needed and feeds the output stream to a synthesis datapath. When the sweep ends, that datapath sees either the last table word or a fixed fallback word.

Top module: `segplay_top`

## Requirements
- R1: After a synchronous active-low reset, `out_word` is 0 and `out_valid` is 0, and no strobe occurs until a segment is started.
- R2: The memory never performs a read and a write in the same cycle. Every host write (`host_we` high for one cycle) stores `host_wdata` at `host_addr`, and a later playback of that address returns the stored word.
- R3: A host write in a cycle where a playback read is due delays that read to the next cycle without a write. The sweep then continues at the same address, so no word is skipped, repeated or reordered.
- R4: A write with `cfg_we` high and `cfg_addr` equal to 0x07, 0x08, 0x09 or 0x0A loads segment 0, 1, 2 or 3 respectively. Writes to any other `cfg_addr` change no segment. The `cfg_wdata` layout is: [2:0] mode, [3] no-dwell, [13:4] start address, [23:14] end address, [39:24] step interval.
- R5: With mode 3'b000 (linear sweep), a started segment outputs the words at addresses start, start+1, … up to and including end. The address counts modulo 1024, so a start above the end wraps through address 0.
- R6: With no host writes, consecutive words of a linear sweep strobe out exactly max(interval, 1) + 2 cycles apart.
- R7: When a linear sweep with no-dwell clear reaches its end address, `out_word` keeps the last word and no further strobe occurs.
- R8: When a linear sweep with no-dwell set finishes, exactly one more strobe follows the last word, and it carries `fixed_word`.
- R9: With any mode other than 3'b000, the segment outputs only the word at its start address and then holds it, whatever its no-dwell flag says.
- R10: `out_valid` is high for exactly one cycle per new output value, and `out_word` changes only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host memory write strobe (has priority) |
| host_addr | input | 10 | Host memory write address |
| host_wdata | input | 32 | Host memory write data |
| cfg_we | input | 1 | Segment control register write strobe |
| cfg_addr | input | 8 | Register address; 0x07..0x0A select segments 0..3 |
| cfg_wdata | input | 40 | Segment control word |
| play_start | input | 1 | Start pulse for the selected segment |
| play_seg | input | 2 | Segment index sampled with `play_start` |
| fixed_word | input | 32 | Fallback value shown after a no-dwell sweep |
| out_word | output | 32 | Registered playback output |
| out_valid | output | 1 | One-cycle strobe marking a new `out_word` |

## Verification
The bench runs three cases that a faulty design would get wrong:

- **Writes during a sweep.** It issues a long burst of back-to-back host writes in the middle of a sweep, then alternating writes. A design that dropped the halted read, or moved the address while stalled, would skip or repeat table words. It also rewrites a table word shortly before that word is played.
- **Wrapping sweep.** It plays a sweep that wraps from address 1023 to 0. An address counter that saturated or ran past the end would emit wrong or extra words.
- **Sweep endings and pacing.** It checks the no-dwell ending, the hold ending and a non-linear mode, where a design that mis-handled the ending would emit an extra strobe or a wrong final value. It measures the strobe spacing at interval 0 and interval 4. This is where an off-by-one counter reload, or an end step that races the output register, shows up.

It also writes to register addresses next to the segment block, so that a decoder that looks only at the low address bits would corrupt segment 0.

// File: rtl/segplay_pkg.sv
// Package: shared widths and types for the segment playback controller.
// Assumes a fixed 40-bit segment control word whose layout is fixed here.
package segplay_pkg;
    parameter int ADDR_W  = 10;
    parameter int DATA_W  = 32;
    parameter int RATE_W  = 16;
    parameter int MODE_W  = 3;
    parameter int NUM_SEG = 4;
    localparam int SEL_W  = $clog2(NUM_SEG);

    localparam logic [MODE_W-1:0] MODE_LINEAR = '0;

    // Segment control word; field positions follow cfg_wdata bit order.
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [ADDR_W-1:0] fin;
        logic [ADDR_W-1:0] beg;
        logic              nodwell;
        logic [MODE_W-1:0] mode;
    } seg_word_t;

    localparam int SEGW_W = $bits(seg_word_t);
endpackage

// File: rtl/segplay_regs.sv
// Module: bank of segment control registers.
// One register per segment, written when cfg_addr equals BASE + index.
// Any other address is ignored. The selected word is read combinationally.
module segplay_regs
    import segplay_pkg::*;
#(
    parameter int          N    = NUM_SEG,
    parameter logic [7:0]  BASE = 8'h07,
    localparam int         SW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_addr,
    input  seg_word_t       cfg_word,
    input  logic [SW-1:0]   sel,
    output seg_word_t       seg_out
);
    seg_word_t regs [N];

    for (genvar g = 0; g < N; g++) begin : g_seg
        localparam logic [7:0] MY_ADDR = BASE + 8'(g);
        // Load this segment word on a matching register write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (cfg_we && cfg_addr == MY_ADDR) begin
                regs[g] <= cfg_word;
            end
        end
    end

    assign seg_out = regs[sel];
endmodule

// File: rtl/segplay_mem.sv
// Module: single-port synchronous memory.
// A write and a read share one address. When both are requested, the write
// wins and no read takes place. Read data is registered, and rvalid marks
// the cycle after a read. The array itself has no reset.
module segplay_mem
    import segplay_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] mem [DEPTH];

    // Port access: a write has precedence over a read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end

    // Read-complete flag, one cycle after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= re && !we;
    end
endmodule

// File: rtl/segplay_seq.sv
// Module: playback sequencer.
// Latches a segment word on start. It requests one read per address and
// defers a read while the host is writing. After each read it counts the
// step interval, then advances the address or finishes.
// Assumes the read data arrives one cycle after ren (rvalid).
module segplay_seq
    import segplay_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  seg_word_t     seg_in,
    input  logic          host_we,
    input  logic          rvalid,
    output logic          ren,
    output logic          pend,
    output logic [AW-1:0] addr,
    output logic          fix_pulse
);
    logic          active;
    logic [RW-1:0] cnt;
    seg_word_t     cur;
    logic          linear;
    logic          last;

    assign linear = (cur.mode == MODE_LINEAR);
    assign last   = !linear || (addr == cur.fin);
    assign ren    = active && pend && !host_we;

    // Segment state machine: start, read, count down, then advance or end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pend      <= 1'b0;
            addr      <= '0;
            cnt       <= '0;
            cur       <= '0;
            fix_pulse <= 1'b0;
        end else begin
            fix_pulse <= 1'b0;
            if (start) begin
                active <= 1'b1;
                pend   <= 1'b1;
                addr   <= seg_in.beg;
                cnt    <= '0;
                cur    <= seg_in;
            end else if (active) begin
                if (ren) begin
                    pend <= 1'b0;
                    cnt  <= cur.rate;
                end else if (!pend) begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!rvalid) begin
                        if (last) begin
                            active    <= 1'b0;
                            fix_pulse <= linear && cur.nodwell;
                        end else begin
                            addr <= addr + 1'b1;
                            pend <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/segplay_top.sv
// Module: segment playback controller top.
// Shares one memory port between host writes, which win, and playback
// reads. Registers the output word and strobes out_valid once per new value.
module segplay_top
    import segplay_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = SEGW_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          play_start,
    input  logic [SW-1:0] play_seg,
    input  logic [DW-1:0] fixed_word,
    output logic [DW-1:0] out_word,
    output logic          out_valid
);
    seg_word_t     sel_word;
    logic          mem_re;
    logic          mem_rvalid;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] port_addr;
    logic          seq_pend;
    logic          fix_pulse;

    segplay_regs #(.N(NUM_SEG), .BASE(8'h07)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_word (seg_word_t'(cfg_wdata)),
        .sel      (play_seg),
        .seg_out  (sel_word)
    );

    segplay_seq #(.AW(AW), .RW(RATE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (play_start),
        .seg_in    (sel_word),
        .host_we   (host_we),
        .rvalid    (mem_rvalid),
        .ren       (mem_re),
        .pend      (seq_pend),
        .addr      (seq_addr),
        .fix_pulse (fix_pulse)
    );

    assign port_addr = host_we ? host_addr : seq_addr;

    segplay_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (host_we),
        .re     (mem_re),
        .addr   (port_addr),
        .wdata  (host_wdata),
        .rdata  (mem_rdata),
        .rvalid (mem_rvalid)
    );

    // Output register: table word on read completion, fallback on no-dwell end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (mem_rvalid) begin
                out_word  <= mem_rdata;
                out_valid <= 1'b1;
            end else if (fix_pulse) begin
                out_word  <= fixed_word;
                out_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/segplay_chk.sv
// Module: assertion checker bound to segplay_top.
// Observes the memory port, the sequencer address and the output register.
module segplay_chk #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_we,
    input logic          ren,
    input logic          pend,
    input logic          play_start,
    input logic [AW-1:0] play_addr,
    input logic          rvalid,
    input logic          fix_pulse,
    input logic [DW-1:0] out_word,
    input logic          out_valid
);
    // R2
    no_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren |-> !host_we);

    // R3
    preempt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && host_we && !play_start) |=> (pend && $stable(play_addr)));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(play_start) && play_addr != $past(play_addr))
            |-> play_addr == AW'($past(play_addr) + 1'b1));

    // R10
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

    // R10
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(rvalid) || $past(fix_pulse)));
endmodule

bind segplay_top segplay_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .ren        (mem_re),
    .pend       (seq_pend),
    .play_start (play_start),
    .play_addr  (seq_addr),
    .rvalid     (mem_rvalid),
    .fix_pulse  (fix_pulse),
    .out_word   (out_word),
    .out_valid  (out_valid)
);

// File: tb/tb_segplay_top.sv
// Scoreboard bench: drivers push expected words, a monitor pops and compares.
module tb_segplay_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [39:0] cfg_wdata = '0;
    logic        play_start = 1'b0;
    logic [1:0]  play_seg = '0;
    logic [31:0] fixed_word = 32'hFEED_F00D;
    logic [31:0] out_word;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] model [1024];
    logic [2:0]  s_mode [4];
    logic        s_nd   [4];
    logic [9:0]  s_beg  [4];
    logic [9:0]  s_fin  [4];

    logic [31:0] exp_q [$];
    string       tag_q [$];
    int          vt_q  [$];

    segplay_top dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .play_start(play_start), .play_seg(play_seg), .fixed_word(fixed_word),
        .out_word(out_word), .out_valid(out_valid)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            vt_q.push_back(cyc);
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10 unexpected strobe: actual %h expected none", out_word);
            end else begin
                check(tag_q.pop_front(), out_word, exp_q.pop_front());
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        host_we = 1'b1; host_addr = 10'(a); host_wdata = d;
        model[a] = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] ra, input logic [39:0] w);
        cfg_we = 1'b1; cfg_addr = ra; cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    function automatic logic [39:0] pack(logic [2:0] m, logic nd, int b, int f, int r);
        return {16'(r), 10'(f), 10'(b), nd, m};
    endfunction

    task automatic cfg_seg(input int s, input logic [2:0] m, input logic nd,
                           input int b, input int f, input int r);
        s_mode[s] = m; s_nd[s] = nd; s_beg[s] = 10'(b); s_fin[s] = 10'(f);
        cfg_write(8'h07 + 8'(s), pack(m, nd, b, f, r));
    endtask

    // Driver: push the expected words of a segment, then pulse start.
    task automatic play(input int s, input string tag);
        logic [9:0] a;
        a = s_beg[s];
        if (s_mode[s] != 3'b000) begin
            exp_q.push_back(model[a]); tag_q.push_back("R9");
        end else begin
            forever begin
                exp_q.push_back(model[a]); tag_q.push_back(tag);
                if (a == s_fin[s]) break;
                a = a + 10'd1;
            end
            if (s_nd[s]) begin
                exp_q.push_back(fixed_word); tag_q.push_back("R8");
            end
        end
        vt_q.delete();
        play_seg = 2'(s); play_start = 1'b1;
        tick();
        play_start = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 3000) begin tick(); n++; end
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d words missing expected 0", tag, exp_q.size());
            exp_q.delete(); tag_q.delete();
        end
        repeat (20) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) tick();
        // R1 reset state
        check("R1", 32'(out_valid), 32'd0);
        check("R1", out_word, 32'd0);
        rst_n = 1'b1;
        repeat (5) tick();
        check("R1", 32'(out_valid), 32'd0);

        for (int i = 0; i < 64; i++) host_write(i, 32'h5A00_0000 | 32'(i * 7 + 1));
        for (int i = 1020; i < 1024; i++) host_write(i, 32'hC300_0000 | 32'(i));

        // R5 linear sweep, R7 hold at end
        cfg_seg(0, 3'b000, 1'b0, 5, 9, 3);
        play(0, "R5");
        drain("R5");
        check("R7", out_word, model[9]);

        // R8 no-dwell ending, R6 interval 0
        cfg_seg(1, 3'b000, 1'b1, 20, 23, 0);
        play(1, "R5");
        drain("R8");
        check("R6", 32'(vt_q[2] - vt_q[1]), 32'd3);
        check("R8", out_word, fixed_word);

        // R5 wrap through address 0
        cfg_seg(3, 3'b000, 1'b0, 1022, 1, 1);
        play(3, "R5");
        drain("R5");
        check("R6", 32'(vt_q[1] - vt_q[0]), 32'd3);

        // R9 non-linear mode holds the start word
        cfg_seg(2, 3'b101, 1'b1, 30, 35, 2);
        play(2, "R9");
        drain("R9");
        check("R9", out_word, model[30]);

        // R6 interval 4
        cfg_seg(2, 3'b000, 1'b0, 40, 42, 4);
        play(2, "R6");
        drain("R6");
        check("R6", 32'(vt_q[1] - vt_q[0]), 32'd6);
        check("R6", 32'(vt_q[2] - vt_q[1]), 32'd6);

        // R4 neighbouring register addresses leave segment 0 alone
        cfg_write(8'h06, pack(3'b000, 1'b1, 45, 47, 0));
        cfg_write(8'h0B, pack(3'b000, 1'b1, 50, 52, 0));
        cfg_write(8'h0F, pack(3'b000, 1'b1, 55, 57, 0));
        play(0, "R4");
        drain("R4");

        // R3 write preemption mid-sweep, with a late table update
        cfg_seg(0, 3'b000, 1'b0, 10, 14, 2);
        host_write(14, 32'hABCD_0014);
        play(0, "R3");
        repeat (6) tick();
        for (int i = 0; i < 30; i++) host_write(200 + i, 32'h7700_0000 | 32'(i));
        for (int i = 30; i < 50; i++) begin
            host_write(200 + i, 32'h7700_0000 | 32'(i));
            tick();
        end
        drain("R3");

        // R2 words written during the sweep landed in memory
        cfg_seg(1, 3'b000, 1'b0, 228, 232, 0);
        play(1, "R2");
        drain("R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule